// File: doc/BRIEF.md
# Oscillator Source Select and Stop Interlock Controller

This block decides which of three oscillators clocks the CPU of a small microcontroller: an internal ring oscillator, a high-speed system oscillator or a low-rate subsystem oscillator. It also holds the stop requests for the ring and high-speed oscillators. Software programs it through four byte-wide registers on a simple single-cycle write port. The block drives registered select and enable outputs toward the clock tree. It is synchronous control logic only; glitch-free switching of the clocks themselves is left to the clock tree.

Every write is screened against interlock rules before it is applied. The rules stop software from halting the oscillator the CPU is running from, and from switching onto an oscillator that is stopped. A write that breaks a rule has no effect on any register, select or enable. It raises a sticky error flag instead, which software clears by writing 1 to it. Out of reset the CPU runs from the ring oscillator and both stoppable oscillators are enabled.

Register map (`addr`): 0 = clock control (bit 4 `sub_sel`, bit 7 `hs_halt`, bit 3 reserved), 1 = main mode (bit 0 `main_req`, bit 1 `main_stat` read-only, bit 7 `err` write-1-to-clear), 2 = ring control (bit 0 `ring_stop`), 3 = high-speed control (bit 7 `hs_stop`). Unlisted bits read 0 and ignore writes. `rdata` is registered: it shows the register addressed by `addr` one clock after `addr` is presented.

Top module: `clksrc_ctrl`

## Requirements
- R1: After reset, cpu_src = 0 (ring), ring_osc_en = 1, hs_osc_en = 1, periph_ring_div = 1, and registers 0 to 3 all read 0.
- R2: A write to register 0 with bit 4 `sub_sel` = 1 is always accepted and selects the subsystem clock (cpu_src = 2). Register 0 bit 4 reads back 1.
- R3: Setting `ring_stop` (register 2 bit 0) takes effect only when `main_stat` = 1 and `main_req` = 1. When it takes effect, ring_osc_en goes to 0. Clearing `ring_stop` is always accepted.
- R4: Setting `hs_stop` (register 3 bit 7) takes effect only when `main_stat` = 0 and `sub_sel` = 0. While the subsystem clock is selected it has no effect.
- R5: Setting `hs_halt` (register 0 bit 7) is accepted only when `sub_sel` is already 1 and the same write keeps it at 1. hs_osc_en = 0 whenever `hs_stop` or `hs_halt` is set.
- R6: A change of `sub_sel` from 1 to 0 is accepted only when `main_stat` = 1, `main_req` = 1 and the same write has `hs_halt` = 0.
- R7: Changing `main_req` to 1 requires hs_osc_en = 1, and changing it to 0 requires `ring_stop` = 0. `main_stat` (register 1 bit 1) copies an accepted `main_req` one clock later.
- R8: A rejected write changes no register and no output, and sets `err` (register 1 bit 7). A write of 1 to that bit in an accepted register-1 write clears it. A rejected write that also carries the clear leaves `err` set.
- R9: Reserved bit 3 of register 0 reads 0 whatever value is written to it.
- R10: periph_ring_div is 1 exactly when the CPU runs from the ring oscillator (peripherals then receive the divided ring clock, typically 240 kHz).
- R11: cpu_src encoding: 0 = ring, 1 = high-speed, 2 = subsystem. `sub_sel` has priority over `main_stat`, and the CPU is never selected onto an oscillator whose enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at addr |
| addr | input | ADDR_W (2) | Register index for writes and readback |
| wdata | input | DATA_W (8) | Write data |
| rdata | output | DATA_W (8) | Registered readback of the register at addr |
| cpu_src | output | 2 | CPU clock source select, registered |
| ring_osc_en | output | 1 | Ring oscillator enable |
| hs_osc_en | output | 1 | High-speed oscillator enable |
| periph_ring_div | output | 1 | Peripheral clock is the divided ring clock |

## Verification
A wrong accept decision in the interlock shows within two clocks as a select or enable that differs from the value implied by the register history. The same fault also shows as a set or missing `err` bit on the next readback. A stale `main_stat` shows first as cpu_src lagging or leading a `main_req` change by a cycle. It shows next as later stop requests being wrongly accepted or refused, so the fault keeps appearing for the rest of the run. A random write sequence with a model is compared after every write, so any divergence is caught at the write that caused it.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
  typedef enum logic [1:0] {
    SRC_RING = 2'd0,
    SRC_HS   = 2'd1,
    SRC_SUB  = 2'd2
  } cpu_src_e;

  localparam int REG_CLK  = 0;
  localparam int REG_MODE = 1;
  localparam int REG_RING = 2;
  localparam int REG_HS   = 3;

  localparam int B_SUB_SEL  = 4;
  localparam int B_RSV      = 3;
  localparam int B_HS_HALT  = 7;
  localparam int B_MAIN_REQ = 0;
  localparam int B_MAIN_ST  = 1;
  localparam int B_ERR      = 7;
  localparam int B_RSTOP    = 0;
  localparam int B_HSTOP    = 7;

  typedef struct packed {
    logic sub_sel;
    logic hs_halt;
    logic main_req;
    logic main_stat;
    logic ring_stop;
    logic hs_stop;
    logic err;
  } ctl_state_t;
endpackage

// File: rtl/clksrc_guard.sv
module clksrc_guard
  import clksrc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  ctl_state_t        st,
  output logic              we_clk,
  output logic              we_mode,
  output logic              we_ring,
  output logic              we_hs,
  output logic              viol,
  output logic              err_clr
);
  logic n_sub, n_halt, n_req, n_rstop, n_hstop;
  logic ok_clk, ok_mode, ok_ring, ok_hs, hs_alive, ok_sel;
  logic [3:0] hit;
  logic unused_wbits;

  assign n_sub   = wdata[B_SUB_SEL];
  assign n_halt  = wdata[B_HS_HALT];
  assign n_req   = wdata[B_MAIN_REQ];
  assign n_rstop = wdata[B_RSTOP];
  assign n_hstop = wdata[B_HSTOP];
  assign unused_wbits = ^{wdata[DATA_W-1:0]};

  assign hs_alive = !(st.hs_stop || st.hs_halt);

  // R6: leaving subsystem needs high-speed active as main; R5: halt only on subsystem
  assign ok_clk  = (n_sub || !st.sub_sel || (st.main_stat && st.main_req && !n_halt))
                && (!n_halt || (st.sub_sel && n_sub));
  // R7: never switch main onto a stopped oscillator
  assign ok_mode = (n_req == st.main_req) || (n_req ? hs_alive : !st.ring_stop);
  // R3
  assign ok_ring = !n_rstop || (st.main_stat && st.main_req);
  // R4
  assign ok_hs   = !n_hstop || (!st.main_stat && !st.main_req && !st.sub_sel);

  generate
    for (genvar i = 0; i < 4; i++) begin : g_hit
      assign hit[i] = wr_en && (addr == ADDR_W'(i));
    end
  endgenerate

  always_comb begin
    unique case (addr[1:0])
      2'd0:    ok_sel = ok_clk;
      2'd1:    ok_sel = ok_mode;
      2'd2:    ok_sel = ok_ring;
      default: ok_sel = ok_hs;
    endcase
  end

  assign we_clk  = hit[REG_CLK]  && ok_clk;
  assign we_mode = hit[REG_MODE] && ok_mode;
  assign we_ring = hit[REG_RING] && ok_ring;
  assign we_hs   = hit[REG_HS]   && ok_hs;
  assign viol    = wr_en && !ok_sel;
  assign err_clr = we_mode && wdata[B_ERR];
endmodule

// File: rtl/clksrc_state.sv
module clksrc_state
  import clksrc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_clk,
  input  logic              we_mode,
  input  logic              we_ring,
  input  logic              we_hs,
  input  logic              viol,
  input  logic              err_clr,
  input  logic [DATA_W-1:0] wdata,
  output ctl_state_t        st
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else begin
      if (we_clk) begin
        st.sub_sel <= wdata[B_SUB_SEL];
        st.hs_halt <= wdata[B_HS_HALT];
      end
      if (we_mode) st.main_req  <= wdata[B_MAIN_REQ];
      if (we_ring) st.ring_stop <= wdata[B_RSTOP];
      if (we_hs)   st.hs_stop   <= wdata[B_HSTOP];
      st.main_stat <= st.main_req;
      if (viol)         st.err <= 1'b1;
      else if (err_clr) st.err <= 1'b0;
    end
  end

  a_r3_ring_stop_guard: assert property (@(posedge clk) disable iff (rst)
    $rose(st.ring_stop) |-> $past(st.main_stat && st.main_req));
  a_r4_hs_stop_guard: assert property (@(posedge clk) disable iff (rst)
    $rose(st.hs_stop) |-> $past(!st.main_stat && !st.sub_sel));
  a_r5_halt_on_sub: assert property (@(posedge clk) disable iff (rst)
    $rose(st.hs_halt) |-> $past(st.sub_sel));
  a_r6_leave_sub: assert property (@(posedge clk) disable iff (rst)
    $fell(st.sub_sel) |-> $past(st.main_stat && st.main_req));
endmodule

// File: rtl/clksrc_out.sv
module clksrc_out
  import clksrc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  ctl_state_t        st,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        cpu_src,
  output logic              ring_osc_en,
  output logic              hs_osc_en,
  output logic              periph_ring_div
);
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    unique case (addr[1:0])
      2'd0: begin
        rd_mux[B_SUB_SEL] = st.sub_sel;
        rd_mux[B_HS_HALT] = st.hs_halt;
      end
      2'd1: begin
        rd_mux[B_MAIN_REQ] = st.main_req;
        rd_mux[B_MAIN_ST]  = st.main_stat;
        rd_mux[B_ERR]      = st.err;
      end
      2'd2:    rd_mux[B_RSTOP] = st.ring_stop;
      default: rd_mux[B_HSTOP] = st.hs_stop;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata           <= '0;
      cpu_src         <= SRC_RING;
      ring_osc_en     <= 1'b1;
      hs_osc_en       <= 1'b1;
      periph_ring_div <= 1'b1;
    end else begin
      rdata           <= rd_mux;
      cpu_src         <= st.sub_sel ? SRC_SUB : (st.main_stat ? SRC_HS : SRC_RING);
      ring_osc_en     <= !st.ring_stop;
      hs_osc_en       <= !(st.hs_stop || st.hs_halt);
      periph_ring_div <= !st.sub_sel && !st.main_stat;
    end
  end

  a_r11_hs_alive: assert property (@(posedge clk) disable iff (rst)
    (cpu_src == SRC_HS) |-> hs_osc_en);
  a_r11_ring_alive: assert property (@(posedge clk) disable iff (rst)
    (cpu_src == SRC_RING) |-> ring_osc_en);
  a_r11_legal_code: assert property (@(posedge clk) disable iff (rst)
    cpu_src != 2'd3);
  a_r9_rsv_zero: assert property (@(posedge clk) disable iff (rst)
    $past(addr[1:0] == 2'd0) |-> (rdata[B_RSV] == 1'b0));
endmodule

// File: rtl/clksrc_ctrl.sv
module clksrc_ctrl
  import clksrc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        cpu_src,
  output logic              ring_osc_en,
  output logic              hs_osc_en,
  output logic              periph_ring_div
);
  ctl_state_t st;
  logic we_clk, we_mode, we_ring, we_hs, viol, err_clr;

  clksrc_guard #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_guard (
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .st(st),
    .we_clk(we_clk), .we_mode(we_mode), .we_ring(we_ring), .we_hs(we_hs),
    .viol(viol), .err_clr(err_clr)
  );

  clksrc_state #(.DATA_W(DATA_W)) u_state (
    .clk(clk), .rst(rst),
    .we_clk(we_clk), .we_mode(we_mode), .we_ring(we_ring), .we_hs(we_hs),
    .viol(viol), .err_clr(err_clr), .wdata(wdata), .st(st)
  );

  clksrc_out #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst(rst), .addr(addr), .st(st), .rdata(rdata),
    .cpu_src(cpu_src), .ring_osc_en(ring_osc_en), .hs_osc_en(hs_osc_en),
    .periph_ring_div(periph_ring_div)
  );
endmodule

// File: tb/clksrc_ctrl_bench.sv
`timescale 1ns/1ps
module clksrc_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] cpu_src;
  logic ring_osc_en, hs_osc_en, periph_ring_div;

  int checks = 0;
  int fails = 0;

  // bench model of the register state
  bit m_sub, m_halt, m_req, m_rstop, m_hstop, m_err;

  always #2 clk = ~clk;

  clksrc_ctrl u_clksrc_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cpu_src(cpu_src), .ring_osc_en(ring_osc_en),
    .hs_osc_en(hs_osc_en), .periph_ring_div(periph_ring_div)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic bit hs_alive();
    return !(m_hstop || m_halt);
  endfunction

  function automatic logic [1:0] exp_src();
    return m_sub ? 2'd2 : (m_req ? 2'd1 : 2'd0);
  endfunction

  function automatic logic [7:0] exp_reg(int a);
    case (a)
      0: return {m_halt, 2'b00, m_sub, 4'b0000};
      1: return {m_err, 5'b0, m_req, m_req};
      2: return {7'b0, m_rstop};
      default: return {m_hstop, 7'b0};
    endcase
  endfunction

  // R8: apply one write to the model following the requirement rules
  function automatic void model_write(int a, logic [7:0] d);
    bit ok;
    case (a)
      0: ok = (d[4] || !m_sub || (m_req && !d[7])) && (!d[7] || (m_sub && d[4]));
      1: ok = (d[0] == m_req) || (d[0] ? hs_alive() : !m_rstop);
      2: ok = !d[0] || m_req;
      default: ok = !d[7] || (!m_req && !m_sub);
    endcase
    if (!ok) begin
      m_err = 1'b1;
      return;
    end
    case (a)
      0: begin m_sub = d[4]; m_halt = d[7]; end
      1: begin m_req = d[0]; if (d[7]) m_err = 1'b0; end
      2: m_rstop = d[0];
      default: m_hstop = d[7];
    endcase
  endfunction

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a[1:0]; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(int a, output logic [7:0] v);
    addr = a[1:0];
    @(negedge clk);
    v = rdata;
  endtask

  task automatic check_outs(string tag);
    chk({tag, " cpu_src"}, {6'b0, cpu_src}, {6'b0, exp_src()});
    chk({tag, " ring_en"}, {7'b0, ring_osc_en}, {7'b0, !m_rstop});
    chk({tag, " hs_en"}, {7'b0, hs_osc_en}, {7'b0, hs_alive()});
    chk("R10 periph_div", {7'b0, periph_ring_div}, {7'b0, exp_src() == 2'd0});
  endtask

  task automatic check_reg(string tag, int a);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp_reg(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_outs("R1");
    for (int a = 0; a < 4; a++) check_reg("R1 reg", a);

    wr(2, 8'h01);            // ring stop while on ring: refused
    check_outs("R3 refused");
    check_reg("R8 err set", 1);
    wr(1, 8'h80);            // clear err
    check_reg("R8 err clear", 1);

    wr(1, 8'h01);            // switch main to high-speed
    check_outs("R7 to hs");
    check_reg("R7 main_stat", 1);
    wr(2, 8'h01);            // ring stop now legal
    check_outs("R3 accepted");
    wr(1, 8'h00);            // back to ring refused: ring stopped
    check_outs("R7 refused");
    wr(3, 8'h80);            // hs stop while main on hs: refused
    check_outs("R4 refused");
    wr(1, 8'h80);
    check_reg("R8 clear", 1);

    wr(0, 8'h18);            // subsystem + reserved bit
    check_outs("R2 sub");
    check_reg("R9 reserved", 0);
    wr(0, 8'h90);            // halt hs while on subsystem
    check_outs("R5 halt");
    wr(0, 8'h80);            // leave subsystem with halt set: refused
    check_outs("R6 refused");
    wr(1, 8'h81);            // rejected? no: main_req unchanged -> accepted, err cleared
    check_reg("R8 clear ok", 1);
    wr(0, 8'h00);            // leave subsystem legally
    check_outs("R6 accepted");
    wr(0, 8'h10);
    wr(2, 8'h00);
    wr(1, 8'h00);            // main to ring under subsystem
    wr(3, 8'h80);            // hs stop under subsystem: no effect
    check_outs("R4 sub no effect");
    wr(0, 8'h00);            // leave subsystem with main on ring: refused
    check_outs("R6 main ring");
    wr(1, 8'h01);
    wr(0, 8'h00);
    wr(1, 8'h80);
    check_outs("R11 hs main");
    wr(1, 8'h00);
    wr(3, 8'h80);            // hs stop on ring: accepted
    check_outs("R4 accepted");
    wr(1, 8'h81);            // to hs while stopped: refused, clear ignored
    check_outs("R7 hs stopped");
    check_reg("R8 set wins", 1);
    wr(3, 8'h00);

    seed = $urandom(32'h5eed_c10c);
    for (int i = 0; i < 400; i++) begin
      int a;
      a = int'($urandom % 4);
      wr(a, 8'($urandom) & 8'h99);
      check_outs("R11 random");
      check_reg("R8 random", 1);
      check_reg("R9 random", 0);
    end
    rd(3, v);
    chk("R4 final", v, exp_reg(3));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule